// File: doc/BRIEF.md
# Instruction Fetch Front End

This block produces the instruction stream for a scalar five-stage pipeline. It owns the program counter and presents one fetch address per cycle to a synchronous instruction memory. That memory returns the addressed 32-bit word on the following clock edge. The memory's output register acts as the instruction half of the fetch/decode boundary. The block keeps the matching PC and a valid bit beside it.

With no other input, the address advances by four bytes every cycle. Decode computes branch and jump targets. It resolves the branch condition after reading its operands. When a transfer of control is taken, decode raises a redirect with the target. The PC is then loaded with that target in place of the incremented value. The one sequential word fetched in the same cycle is turned into a bubble. This gives a two-cycle loop from fetching a branch to fetching its target.

A stall from later stages freezes the PC and the fetch/decode contents. A redirect takes priority over a stall.

Top module: `fetch_front`

## Requirements
- R1: Every fetch address and every decode PC is a multiple of four. Each instruction word is 32 bits wide.
- R2: With stall_i and redirect_i low, imem_addr_o rises by 4 each cycle. In the next cycle fd_pc_o equals the previous fetch address and fd_valid_o is 1.
- R3: The word read at fetch address A appears on fd_instr_o in the cycle after A was presented, together with fd_pc_o equal to A.
- R4: When redirect_i is high in a cycle, imem_addr_o in the next cycle equals the redirect_target_i value of that cycle.
- R5: In the cycle after a redirect, fd_valid_o is 0. In the cycle after that, fd_valid_o is 1, fd_pc_o is the target and fd_instr_o is the target's word.
- R6: While stall_i is high and redirect_i is low, the PC, fd_valid_o, fd_pc_o and fd_instr_o keep their values. imem_addr_o shows fd_pc_o so that the memory re-reads the held word.
- R7: When stall_i and redirect_i are both high, the redirect is applied exactly as in R4 and R5.
- R8: While rst_n is low at a clock edge, the PC is loaded with RESET_VEC and fd_valid_o is cleared. The first valid instruction, with fd_pc_o equal to RESET_VEC, appears one cycle after rst_n is seen high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| stall_i | input | 1 | Hold request from later stages |
| redirect_i | input | 1 | Taken branch or jump resolved in decode |
| redirect_target_i | input | AW | Word-aligned target address for the redirect |
| imem_addr_o | output | AW | Byte address sent to the instruction memory |
| imem_rdata_i | input | ILEN | Word returned by the memory one cycle after its address |
| fd_valid_o | output | 1 | Fetch/decode entry holds a real instruction |
| fd_pc_o | output | AW | Address of the instruction in the fetch/decode entry |
| fd_instr_o | output | ILEN | Instruction in the fetch/decode entry |

## Verification
The assertions assume that redirect targets are word-aligned. They also assume that the memory re-reads whatever address it is given on every edge, so that a held address yields a held word. The bench drives only aligned targets. It raises redirect only while decode holds a valid instruction, as a real decode stage would. Its memory model is a plain array that is read on every rising edge. Stimulus changes only just after the falling edge, so stall and redirect are stable around each rising edge.

// File: rtl/fetch_pkg.sv
// Shared types for the fetch front end.
// Assumes nothing beyond being compiled first.
package fetch_pkg;
    // Choice made each cycle for the program counter.
    typedef enum logic [1:0] {
        NPC_SEQ   = 2'd0,
        NPC_HOLD  = 2'd1,
        NPC_REDIR = 2'd2
    } npc_sel_e;
endpackage

// File: rtl/fetch_npc_ctrl.sv
// Next-PC control: picks redirect, hold or sequential advance.
// Assumes redirect_i is raised only for a resolved taken transfer.
module fetch_npc_ctrl
    import fetch_pkg::*;
(
    input  logic     stall_i,
    input  logic     redirect_i,
    output npc_sel_e sel_o
);
    // Priority: redirect first, then stall, otherwise advance.
    always_comb begin
        if (redirect_i)   sel_o = NPC_REDIR;
        else if (stall_i) sel_o = NPC_HOLD;
        else              sel_o = NPC_SEQ;
    end
endmodule

// File: rtl/fetch_pc_reg.sv
// Program counter register: loads the reset vector, steps, holds or
// takes a redirect target. Assumes targets are word-aligned.
module fetch_pc_reg
    import fetch_pkg::*;
#(
    parameter int              AW        = 32,
    parameter int              STEP      = 4,
    parameter logic [AW-1:0]   RESET_VEC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  npc_sel_e      sel_i,
    input  logic [AW-1:0] target_i,
    output logic [AW-1:0] pc_o
);
    localparam logic [AW-1:0] STEP_W = AW'(STEP);

    logic [AW-1:0] pc_q;

    // PC update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_VEC;
        end else begin
            case (sel_i)
                NPC_SEQ:   pc_q <= pc_q + STEP_W;
                NPC_REDIR: pc_q <= target_i;
                default:   pc_q <= pc_q;
            endcase
        end
    end

    assign pc_o = pc_q;

    assert_pc_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[1:0] == 2'b00);
    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == NPC_SEQ) |=> (pc_q == $past(pc_q) + STEP_W));
    assert_redirect_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == NPC_REDIR) |=> (pc_q == $past(target_i)));
    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == NPC_HOLD) |=> $stable(pc_q));
    assert_reset_vec_R8: assert property (@(posedge clk)
        !rst_n |=> (pc_q == RESET_VEC));
endmodule

// File: rtl/fetch_fd_reg.sv
// Fetch/decode side register: valid bit and PC of the word that the
// memory's output register holds. Assumes a memory latency of one cycle.
module fetch_fd_reg
    import fetch_pkg::*;
#(
    parameter int            AW        = 32,
    parameter logic [AW-1:0] RESET_VEC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  npc_sel_e      sel_i,
    input  logic [AW-1:0] pc_i,
    output logic          valid_o,
    output logic [AW-1:0] pc_o
);
    logic          valid_q;
    logic [AW-1:0] pc_q;

    // Capture the issued PC, squash on redirect, hold on stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            pc_q    <= RESET_VEC;
        end else begin
            case (sel_i)
                NPC_SEQ: begin
                    valid_q <= 1'b1;
                    pc_q    <= pc_i;
                end
                NPC_REDIR: begin
                    valid_q <= 1'b0;
                    pc_q    <= pc_i;
                end
                default: begin
                    valid_q <= valid_q;
                    pc_q    <= pc_q;
                end
            endcase
        end
    end

    assign valid_o = valid_q;
    assign pc_o    = pc_q;

    assert_fd_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == NPC_SEQ) |=> (valid_q && pc_q == $past(pc_i)));
    assert_squash_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == NPC_REDIR) |=> !valid_q);
    assert_fd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == NPC_HOLD) |=> ($stable(valid_q) && $stable(pc_q)));
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> !valid_q);
endmodule

// File: rtl/fetch_front.sv
// Instruction fetch front end: PC, sequential advance, decode redirect,
// one-bubble squash and stall hold. Assumes a synchronous instruction
// memory that reads the presented address on every rising edge.
module fetch_front
    import fetch_pkg::*;
#(
    parameter int            AW        = 32,
    parameter int            ILEN      = 32,
    parameter logic [AW-1:0] RESET_VEC = 32'h0000_0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall_i,
    input  logic            redirect_i,
    input  logic [AW-1:0]   redirect_target_i,
    output logic [AW-1:0]   imem_addr_o,
    input  logic [ILEN-1:0] imem_rdata_i,
    output logic            fd_valid_o,
    output logic [AW-1:0]   fd_pc_o,
    output logic [ILEN-1:0] fd_instr_o
);
    localparam int INSTR_BYTES = ILEN / 8;

    npc_sel_e      sel;
    logic [AW-1:0] pc;

    fetch_npc_ctrl u_ctrl (
        .stall_i    (stall_i),
        .redirect_i (redirect_i),
        .sel_o      (sel)
    );

    fetch_pc_reg #(
        .AW        (AW),
        .STEP      (INSTR_BYTES),
        .RESET_VEC (RESET_VEC)
    ) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (sel),
        .target_i (redirect_target_i),
        .pc_o     (pc)
    );

    fetch_fd_reg #(
        .AW        (AW),
        .RESET_VEC (RESET_VEC)
    ) u_fd (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (sel),
        .pc_i    (pc),
        .valid_o (fd_valid_o),
        .pc_o    (fd_pc_o)
    );

    // While holding, re-read the word already in decode so it stays put.
    always_comb begin
        imem_addr_o = (sel == NPC_HOLD) ? fd_pc_o : pc;
    end

    assign fd_instr_o = imem_rdata_i;

    assert_redirect_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && redirect_i) |=> (!fd_valid_o && imem_addr_o == $past(redirect_target_i)
                                     || stall_i));
    assert_stall_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !redirect_i) |-> (imem_addr_o == fd_pc_o));
endmodule

// File: tb/fetch_front_tb.sv
module fetch_front_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RV = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic        redir = 1'b0;
    logic [31:0] target = '0;
    logic [31:0] imem_addr;
    logic [31:0] imem_rdata = '0;
    logic        fd_valid;
    logic [31:0] fd_pc;
    logic [31:0] fd_instr;

    int checks = 0;
    int failures = 0;

    logic [31:0] mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Synchronous memory, one cycle latency.
    always @(posedge clk) imem_rdata <= mem[imem_addr[9:2]];

    fetch_front #(.RESET_VEC(RV)) u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .stall_i           (stall),
        .redirect_i        (redir),
        .redirect_target_i (target),
        .imem_addr_o       (imem_addr),
        .imem_rdata_i      (imem_rdata),
        .fd_valid_o        (fd_valid),
        .fd_pc_o           (fd_pc),
        .fd_instr_o        (fd_instr)
    );

    function automatic logic [31:0] word_at(logic [31:0] a);
        return 32'hC0DE_0000 | {24'h0, a[9:2]};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // {stall, redirect, target, exp_addr, exp_valid, exp_fd_pc}
    localparam int NV = 16;
    localparam logic [98:0] VEC [NV] = '{
        {1'b0, 1'b0, 32'h0,   32'h100, 1'b0, 32'h0  },
        {1'b0, 1'b0, 32'h0,   32'h104, 1'b1, 32'h100},
        {1'b0, 1'b0, 32'h0,   32'h108, 1'b1, 32'h104},
        {1'b0, 1'b1, 32'h200, 32'h10C, 1'b1, 32'h108},
        {1'b0, 1'b0, 32'h0,   32'h200, 1'b0, 32'h0  },
        {1'b0, 1'b1, 32'h140, 32'h204, 1'b1, 32'h200},
        {1'b0, 1'b0, 32'h0,   32'h140, 1'b0, 32'h0  },
        {1'b0, 1'b1, 32'h180, 32'h144, 1'b1, 32'h140},
        {1'b0, 1'b0, 32'h0,   32'h180, 1'b0, 32'h0  },
        {1'b1, 1'b0, 32'h0,   32'h180, 1'b1, 32'h180},
        {1'b1, 1'b0, 32'h0,   32'h180, 1'b1, 32'h180},
        {1'b0, 1'b0, 32'h0,   32'h184, 1'b1, 32'h180},
        {1'b1, 1'b1, 32'h300, 32'h188, 1'b1, 32'h184},
        {1'b0, 1'b0, 32'h0,   32'h300, 1'b0, 32'h0  },
        {1'b0, 1'b0, 32'h0,   32'h304, 1'b1, 32'h300},
        {1'b0, 1'b0, 32'h0,   32'h308, 1'b1, 32'h304}
    };

    // Watchdog: a hung run is a failure.
    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] prev_addr;
        logic [31:0] held_instr;
        for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 | i;

        // Reset state (R8)
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R8 reset addr", imem_addr, RV);
        chk("R8 reset valid", {31'h0, fd_valid}, 32'h0);

        // Table walk: straight line, back-to-back branches, stalls.
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            stall  = VEC[k][98];
            redir  = VEC[k][97];
            target = VEC[k][96:65];
            #1;
            // R2 R3 R4 R5 R6 R7 table step
            chk($sformatf("R2/R4/R6/R7 addr step %0d", k), imem_addr, VEC[k][64:33]);
            chk($sformatf("R5 valid step %0d", k), {31'h0, fd_valid}, {31'h0, VEC[k][32]});
            chk($sformatf("R1 align step %0d", k), {30'h0, imem_addr[1:0]}, 32'h0);
            if (VEC[k][32]) begin
                chk($sformatf("R3 pc step %0d", k), fd_pc, VEC[k][31:0]);
                chk($sformatf("R3 instr step %0d", k), fd_instr, word_at(VEC[k][31:0]));
            end
            @(negedge clk);
        end
        stall = 1'b0; redir = 1'b0; target = '0;

        // Reset in mid run (R8)
        rst_n = 1'b0;
        @(negedge clk); #1;
        chk("R8 mid reset addr", imem_addr, RV);
        chk("R8 mid reset valid", {31'h0, fd_valid}, 32'h0);
        rst_n = 1'b1;
        #1;
        chk("R8 release valid", {31'h0, fd_valid}, 32'h0);
        @(negedge clk); #1;
        chk("R8 first valid", {31'h0, fd_valid}, 32'h1);
        chk("R8 first pc", fd_pc, RV);
        chk("R3 first instr", fd_instr, word_at(RV));
        chk("R2 second addr", imem_addr, RV + 32'h4);

        // Long straight-line run (R2, R1)
        prev_addr = imem_addr;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk); #1;
            chk("R2 step addr", imem_addr, prev_addr + 32'h4);
            chk("R2 fd pc", fd_pc, prev_addr);
            chk("R2 valid", {31'h0, fd_valid}, 32'h1);
            chk("R1 fd align", {30'h0, fd_pc[1:0]}, 32'h0);
            prev_addr = imem_addr;
        end

        // Long stall (R6)
        held_instr = fd_instr;
        stall = 1'b1;
        #1;
        chk("R6 stall addr", imem_addr, fd_pc);
        for (int n = 0; n < 5; n++) begin
            @(negedge clk); #1;
            chk("R6 held pc", fd_pc, prev_addr - 32'h4);
            chk("R6 held instr", fd_instr, held_instr);
            chk("R6 held valid", {31'h0, fd_valid}, 32'h1);
        end
        stall = 1'b0;
        #1;
        chk("R6 resume addr", imem_addr, prev_addr);

        // Redirect under stall, then check target arrives (R7, R5)
        @(negedge clk);
        stall = 1'b1; redir = 1'b1; target = 32'h0000_0040;
        @(negedge clk);
        stall = 1'b0; redir = 1'b0; target = '0;
        #1;
        chk("R7 target addr", imem_addr, 32'h40);
        chk("R7 bubble", {31'h0, fd_valid}, 32'h0);
        @(negedge clk); #1;
        chk("R5 target valid", {31'h0, fd_valid}, 32'h1);
        chk("R5 target pc", fd_pc, 32'h40);
        chk("R5 target instr", fd_instr, word_at(32'h40));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule